// File: doc/BRIEF.md
# Break and interrupt entry controller

This block sits next to a short in-order pipeline and decides, on each unstalled cycle, whether the instruction in the decode stage is replaced by a jump to a trap vector. It considers five kinds of trap. In order of priority they are a non-maskable break pulse, a held external break, a software break instruction, a debugger-only software break, and a level-sensitive external interrupt. For a taken trap it drives, in the same cycle, a fetch redirect with its target and a register-file write of the return address. At the next clock edge it updates the status bits it owns.

Breaks and interrupts each have their own vector, their own link register and their own enable or in-progress bit. A taken break masks both further maskable breaks and interrupts until the return-from-break instruction. A taken break also saves the user and virtual mode bits, clears them, and drops the load/store reservation. The return-from-break instruction restores the saved modes. A non-maskable pulse that arrives while the pipeline is stalled is kept as pending and is taken on the first free cycle. A status write port, used by a move-to-status instruction, loads the interrupt enable and the two mode bits.

Top module: `trap_entry_ctrl`

## Requirements
- R1: An interrupt is taken only on a cycle where `irq_i`=1, `stall_i`=0, `msr_ie_o`=1, `msr_bip_o`=0 and `eip_i`=0.
- R2: A taken interrupt redirects to `BASE_VEC`+0x10, or to `ll_vec_i` when `LOW_LAT_EN`=1.
- R3: A taken interrupt writes `dec_pc_i` into register 14 in the same cycle (`rf_we_o`=1, `rf_idx_o`=14), and `msr_ie_o` reads 0 from the next cycle on.
- R4: A cycle with `rtid_i`=1 sets `msr_ie_o` to 1 from the next cycle on.
- R5: A taken break (external, non-maskable, or software with an immediate other than the debug value) writes `dec_pc_i` into register 16 (`rf_idx_o`=16) in the same cycle. From the next cycle `msr_bip_o`=1 and `resv_o`=0. External and non-maskable breaks redirect to `BASE_VEC`+0x18.
- R6: On a taken break, `msr_ums_o` takes the old `msr_um_o` and `msr_um_o` becomes 0. Likewise `msr_vms_o` takes the old `msr_vm_o` and `msr_vm_o` becomes 0.
- R7: A cycle with `rtbd_i`=1 and no break taken clears `msr_bip_o` and restores `msr_um_o` from `msr_ums_o` and `msr_vm_o` from `msr_vms_o`.
- R8: `ext_brk_i` has no effect while `msr_bip_o`=1. A non-maskable break is taken even when `msr_bip_o`=1.
- R9: With `DEBUG_EN`=1, a software break whose immediate equals 0x18 pulses `dbg_req_o` for one cycle, makes no redirect and no register write, and leaves `msr_bip_o` unchanged, whatever `BASE_VEC` is.
- R10: A software break with any other immediate redirects to `BASE_VEC` plus the zero-extended immediate.
- R11: While `stall_i`=1 nothing is redirected. A `nm_brk_i` pulse that arrives during a stall stays pending and is taken on the first unstalled cycle, and only once.
- R12: When a break and an interrupt are eligible in the same cycle, the break is taken. The interrupt stays masked until the return from break.
- R13: A cycle with `st_we_i`=1 loads `msr_ie_o`, `msr_um_o` and `msr_vm_o` from `st_ie_i`, `st_um_i` and `st_vm_i`. A cycle with `resv_set_i`=1 sets `resv_o`.
- R14: After reset every status bit is 0 and no redirect, write or debug request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Pipeline stall; no trap is taken |
| irq_i | input | 1 | External interrupt level |
| ext_brk_i | input | 1 | External break level |
| nm_brk_i | input | 1 | Non-maskable break, one-cycle pulse |
| sw_brk_i | input | 1 | Software break instruction in decode |
| sw_imm_i | input | IMM_W | Immediate of the software break |
| rtbd_i | input | 1 | Return-from-break executing |
| rtid_i | input | 1 | Return-from-interrupt executing |
| eip_i | input | 1 | Exception in progress (owned elsewhere) |
| dec_pc_i | input | ADDR_W | PC of the decode-stage instruction |
| ll_vec_i | input | ADDR_W | Vector from the interrupt controller |
| st_we_i | input | 1 | Status write strobe |
| st_ie_i | input | 1 | Interrupt enable value to write |
| st_um_i | input | 1 | User mode value to write |
| st_vm_i | input | 1 | Virtual mode value to write |
| resv_set_i | input | 1 | Set the reservation flag |
| redir_o | output | 1 | Redirect fetch this cycle |
| redir_addr_o | output | ADDR_W | Redirect target |
| rf_we_o | output | 1 | Register-file write of the return address |
| rf_idx_o | output | REG_IDX_W | Link register index |
| rf_data_o | output | ADDR_W | Return address |
| dbg_req_o | output | 1 | Debugger-only break request |
| msr_ie_o | output | 1 | Interrupt enable |
| msr_bip_o | output | 1 | Break in progress |
| msr_um_o | output | 1 | User mode |
| msr_ums_o | output | 1 | Saved user mode |
| msr_vm_o | output | 1 | Virtual mode |
| msr_vms_o | output | 1 | Saved virtual mode |
| resv_o | output | 1 | Load/store reservation |

## Verification
The bound checker tests several rules on every cycle. An interrupt is never taken outside its enable and masking conditions. Each trap kind leaves the status bits it must leave one cycle later, including the saving and clearing of the mode bits. The debug break never redirects or writes. Nothing leaves the block during a stall. The directed scenarios are needed for the rest, which depends on a particular history: the exact vector addresses, the low-latency variant, the break winning over a simultaneous interrupt and that interrupt arriving only after the return, a non-maskable pulse held through a stall and taken exactly once, and a held external break being ignored while a break is in progress.

// File: rtl/trap_pkg.sv
package trap_pkg;

   typedef enum logic [2:0] {
      TK_NONE,
      TK_NMI,
      TK_EXT,
      TK_SWB,
      TK_DBG,
      TK_IRQ
   } trap_kind_e;

   localparam int unsigned IRQ_VEC_OFS = 32'h10;
   localparam int unsigned BRK_VEC_OFS = 32'h18;
   localparam int unsigned DBG_IMM     = 32'h18;

   function automatic logic is_break(trap_kind_e k);
      return (k == TK_NMI) || (k == TK_EXT) || (k == TK_SWB);
   endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
#(
   parameter int unsigned IMM_W    = 16,
   parameter bit          DEBUG_EN = 1'b1
) (
   input  logic             stall_i,
   input  logic             nm_pend_i,
   input  logic             ext_brk_i,
   input  logic             sw_brk_i,
   input  logic [IMM_W-1:0] sw_imm_i,
   input  logic             irq_i,
   input  logic             eip_i,
   input  logic             ie_i,
   input  logic             bip_i,
   output trap_kind_e       kind_o
);

   localparam logic [IMM_W-1:0] DBG_IMM_V = IMM_W'(DBG_IMM);

   logic dbg_hit;

   generate
      if (DEBUG_EN) begin : g_dbg
         assign dbg_hit = (sw_imm_i == DBG_IMM_V);
      end else begin : g_nodbg
         assign dbg_hit = 1'b0;
      end
   endgenerate

   // Priority: non-maskable, external, software, debug, interrupt.
   always_comb begin
      kind_o = TK_NONE;
      if (!stall_i) begin
         if (nm_pend_i)
            kind_o = TK_NMI;
         else if (ext_brk_i && !bip_i)
            kind_o = TK_EXT;
         else if (sw_brk_i && !dbg_hit)
            kind_o = TK_SWB;
         else if (sw_brk_i)
            kind_o = TK_DBG;
         else if (irq_i && ie_i && !bip_i && !eip_i)
            kind_o = TK_IRQ;
      end
   end

endmodule

// File: rtl/trap_vector.sv
module trap_vector
   import trap_pkg::*;
#(
   parameter int unsigned          ADDR_W     = 32,
   parameter int unsigned          IMM_W      = 16,
   parameter int unsigned          REG_IDX_W  = 5,
   parameter logic [ADDR_W-1:0]    BASE_VEC   = '0,
   parameter bit                   LOW_LAT_EN = 1'b0,
   parameter int unsigned          IRQ_LINK   = 14,
   parameter int unsigned          BRK_LINK   = 16
) (
   input  trap_kind_e           kind_i,
   input  logic [ADDR_W-1:0]    dec_pc_i,
   input  logic [ADDR_W-1:0]    ll_vec_i,
   input  logic [IMM_W-1:0]     sw_imm_i,
   output logic                 redir_o,
   output logic [ADDR_W-1:0]    redir_addr_o,
   output logic                 rf_we_o,
   output logic [REG_IDX_W-1:0] rf_idx_o,
   output logic [ADDR_W-1:0]    rf_data_o,
   output logic                 dbg_req_o
);

   localparam logic [ADDR_W-1:0]    IRQ_FIXED = BASE_VEC + ADDR_W'(IRQ_VEC_OFS);
   localparam logic [ADDR_W-1:0]    BRK_TGT   = BASE_VEC + ADDR_W'(BRK_VEC_OFS);
   localparam logic [REG_IDX_W-1:0] IRQ_IDX   = REG_IDX_W'(IRQ_LINK);
   localparam logic [REG_IDX_W-1:0] BRK_IDX   = REG_IDX_W'(BRK_LINK);

   logic [ADDR_W-1:0] irq_tgt;
   logic [ADDR_W-1:0] sw_tgt;

   assign irq_tgt = LOW_LAT_EN ? ll_vec_i : IRQ_FIXED;
   assign sw_tgt  = BASE_VEC + {{(ADDR_W-IMM_W){1'b0}}, sw_imm_i};

   always_comb begin
      redir_o      = 1'b0;
      redir_addr_o = '0;
      rf_we_o      = 1'b0;
      rf_idx_o     = '0;
      rf_data_o    = dec_pc_i;
      dbg_req_o    = 1'b0;
      unique case (kind_i)
         TK_NMI, TK_EXT: begin
            redir_o      = 1'b1;
            redir_addr_o = BRK_TGT;
            rf_we_o      = 1'b1;
            rf_idx_o     = BRK_IDX;
         end
         TK_SWB: begin
            redir_o      = 1'b1;
            redir_addr_o = sw_tgt;
            rf_we_o      = 1'b1;
            rf_idx_o     = BRK_IDX;
         end
         TK_IRQ: begin
            redir_o      = 1'b1;
            redir_addr_o = irq_tgt;
            rf_we_o      = 1'b1;
            rf_idx_o     = IRQ_IDX;
         end
         TK_DBG:  dbg_req_o = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/trap_status.sv
module trap_status
   import trap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  trap_kind_e kind_i,
   input  logic       rtbd_i,
   input  logic       rtid_i,
   input  logic       st_we_i,
   input  logic       st_ie_i,
   input  logic       st_um_i,
   input  logic       st_vm_i,
   input  logic       resv_set_i,
   input  logic       nm_brk_i,
   output logic       ie_o,
   output logic       bip_o,
   output logic       um_o,
   output logic       ums_o,
   output logic       vm_o,
   output logic       vms_o,
   output logic       resv_o,
   output logic       nm_q_o
);

   logic ie_d, bip_d, um_d, ums_d, vm_d, vms_d, resv_d, nm_d;

   always_comb begin
      ie_d   = ie_o;
      bip_d  = bip_o;
      um_d   = um_o;
      ums_d  = ums_o;
      vm_d   = vm_o;
      vms_d  = vms_o;
      resv_d = resv_o | resv_set_i;
      if (st_we_i) begin
         ie_d = st_ie_i;
         um_d = st_um_i;
         vm_d = st_vm_i;
      end
      if (rtid_i)
         ie_d = 1'b1;
      if (rtbd_i) begin
         bip_d = 1'b0;
         um_d  = ums_o;
         vm_d  = vms_o;
      end
      if (is_break(kind_i)) begin
         bip_d  = 1'b1;
         resv_d = 1'b0;
         ums_d  = um_o;
         um_d   = 1'b0;
         vms_d  = vm_o;
         vm_d   = 1'b0;
      end
      if (kind_i == TK_IRQ)
         ie_d = 1'b0;
      nm_d = (nm_q_o | nm_brk_i) & (kind_i != TK_NMI);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_o   <= 1'b0;
         bip_o  <= 1'b0;
         um_o   <= 1'b0;
         ums_o  <= 1'b0;
         vm_o   <= 1'b0;
         vms_o  <= 1'b0;
         resv_o <= 1'b0;
         nm_q_o <= 1'b0;
      end else begin
         ie_o   <= ie_d;
         bip_o  <= bip_d;
         um_o   <= um_d;
         ums_o  <= ums_d;
         vm_o   <= vm_d;
         vms_o  <= vms_d;
         resv_o <= resv_d;
         nm_q_o <= nm_d;
      end
   end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
   import trap_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       IMM_W      = 16,
   parameter int unsigned       REG_IDX_W  = 5,
   parameter logic [ADDR_W-1:0] BASE_VEC   = '0,
   parameter bit                LOW_LAT_EN = 1'b0,
   parameter bit                DEBUG_EN   = 1'b1,
   parameter int unsigned       IRQ_LINK   = 14,
   parameter int unsigned       BRK_LINK   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stall_i,
   input  logic                 irq_i,
   input  logic                 ext_brk_i,
   input  logic                 nm_brk_i,
   input  logic                 sw_brk_i,
   input  logic [IMM_W-1:0]     sw_imm_i,
   input  logic                 rtbd_i,
   input  logic                 rtid_i,
   input  logic                 eip_i,
   input  logic [ADDR_W-1:0]    dec_pc_i,
   input  logic [ADDR_W-1:0]    ll_vec_i,
   input  logic                 st_we_i,
   input  logic                 st_ie_i,
   input  logic                 st_um_i,
   input  logic                 st_vm_i,
   input  logic                 resv_set_i,
   output logic                 redir_o,
   output logic [ADDR_W-1:0]    redir_addr_o,
   output logic                 rf_we_o,
   output logic [REG_IDX_W-1:0] rf_idx_o,
   output logic [ADDR_W-1:0]    rf_data_o,
   output logic                 dbg_req_o,
   output logic                 msr_ie_o,
   output logic                 msr_bip_o,
   output logic                 msr_um_o,
   output logic                 msr_ums_o,
   output logic                 msr_vm_o,
   output logic                 msr_vms_o,
   output logic                 resv_o
);

   generate
      if (IMM_W >= ADDR_W) begin : g_bad_imm
         $error("trap_entry_ctrl: IMM_W must be narrower than ADDR_W");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("trap_entry_ctrl: ADDR_W too small for vector offsets");
      end
      if ((IRQ_LINK >= (1 << REG_IDX_W)) || (BRK_LINK >= (1 << REG_IDX_W))) begin : g_bad_idx
         $error("trap_entry_ctrl: link register index does not fit REG_IDX_W");
      end
      if (IRQ_LINK == BRK_LINK) begin : g_bad_link
         $error("trap_entry_ctrl: interrupt and break link registers must differ");
      end
   endgenerate

   trap_kind_e kind;
   logic       nm_q;
   logic       nm_pend;

   assign nm_pend = nm_q | nm_brk_i;

   trap_arbiter #(
      .IMM_W    (IMM_W),
      .DEBUG_EN (DEBUG_EN)
   ) u_arb (
      .stall_i   (stall_i),
      .nm_pend_i (nm_pend),
      .ext_brk_i (ext_brk_i),
      .sw_brk_i  (sw_brk_i),
      .sw_imm_i  (sw_imm_i),
      .irq_i     (irq_i),
      .eip_i     (eip_i),
      .ie_i      (msr_ie_o),
      .bip_i     (msr_bip_o),
      .kind_o    (kind)
   );

   trap_vector #(
      .ADDR_W     (ADDR_W),
      .IMM_W      (IMM_W),
      .REG_IDX_W  (REG_IDX_W),
      .BASE_VEC   (BASE_VEC),
      .LOW_LAT_EN (LOW_LAT_EN),
      .IRQ_LINK   (IRQ_LINK),
      .BRK_LINK   (BRK_LINK)
   ) u_vec (
      .kind_i       (kind),
      .dec_pc_i     (dec_pc_i),
      .ll_vec_i     (ll_vec_i),
      .sw_imm_i     (sw_imm_i),
      .redir_o      (redir_o),
      .redir_addr_o (redir_addr_o),
      .rf_we_o      (rf_we_o),
      .rf_idx_o     (rf_idx_o),
      .rf_data_o    (rf_data_o),
      .dbg_req_o    (dbg_req_o)
   );

   trap_status u_st (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind_i     (kind),
      .rtbd_i     (rtbd_i),
      .rtid_i     (rtid_i),
      .st_we_i    (st_we_i),
      .st_ie_i    (st_ie_i),
      .st_um_i    (st_um_i),
      .st_vm_i    (st_vm_i),
      .resv_set_i (resv_set_i),
      .nm_brk_i   (nm_brk_i),
      .ie_o       (msr_ie_o),
      .bip_o      (msr_bip_o),
      .um_o       (msr_um_o),
      .ums_o      (msr_ums_o),
      .vm_o       (msr_vm_o),
      .vms_o      (msr_vms_o),
      .resv_o     (resv_o),
      .nm_q_o     (nm_q)
   );

endmodule

// File: rtl/trap_entry_ctrl_chk.sv
module trap_entry_ctrl_chk #(
   parameter int unsigned REG_IDX_W = 5,
   parameter int unsigned IRQ_LINK  = 14,
   parameter int unsigned BRK_LINK  = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 stall_i,
   input logic                 eip_i,
   input logic                 rtbd_i,
   input logic                 st_we_i,
   input logic                 redir_o,
   input logic                 rf_we_o,
   input logic [REG_IDX_W-1:0] rf_idx_o,
   input logic                 dbg_req_o,
   input logic                 msr_ie_o,
   input logic                 msr_bip_o,
   input logic                 msr_um_o,
   input logic                 msr_ums_o,
   input logic                 msr_vm_o,
   input logic                 msr_vms_o,
   input logic                 resv_o
);

   localparam logic [REG_IDX_W-1:0] IRQ_IDX = REG_IDX_W'(IRQ_LINK);
   localparam logic [REG_IDX_W-1:0] BRK_IDX = REG_IDX_W'(BRK_LINK);

   logic irq_take, brk_take;
   assign irq_take = rf_we_o && (rf_idx_o == IRQ_IDX);
   assign brk_take = rf_we_o && (rf_idx_o == BRK_IDX);

   assert_irq_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> (msr_ie_o && !msr_bip_o && !eip_i));

   assert_irq_clears_ie_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> !msr_ie_o);

   assert_brk_sets_bip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      brk_take |=> (msr_bip_o && !resv_o));

   assert_brk_saves_modes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      brk_take |=> (msr_ums_o == $past(msr_um_o)) && !msr_um_o
                   && (msr_vms_o == $past(msr_vm_o)) && !msr_vm_o);

   assert_rtbd_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rtbd_i && !brk_take && !st_we_i) |=> !msr_bip_o
         && (msr_um_o == $past(msr_ums_o)) && (msr_vm_o == $past(msr_vms_o)));

   assert_dbg_no_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req_o |-> (!redir_o && !rf_we_o));

   assert_dbg_keeps_bip_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_req_o && !rtbd_i) |=> (msr_bip_o == $past(msr_bip_o)));

   assert_stall_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |-> (!redir_o && !rf_we_o && !dbg_req_o));

   assert_single_action_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_take, brk_take, dbg_req_o}));

endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(
   .REG_IDX_W (REG_IDX_W),
   .IRQ_LINK  (IRQ_LINK),
   .BRK_LINK  (BRK_LINK)
) u_chk (.*);

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb;

   localparam int unsigned     AW   = 32;
   localparam int unsigned     IW   = 16;
   localparam logic [AW-1:0]   BASE = 32'h0000_4000;
   localparam logic [AW-1:0]   LLV  = 32'h8000_1230;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          stall, irq, ext_brk, nm_brk, sw_brk, rtbd, rtid, eip;
   logic [IW-1:0] sw_imm;
   logic [AW-1:0] dec_pc;
   logic          st_we, st_ie, st_um, st_vm, resv_set;

   logic          redir, rf_we, dbg, ie, bip, um, ums, vm, vms, resv;
   logic [AW-1:0] raddr, rdata;
   logic [4:0]    ridx;

   logic          l_redir, l_rf_we, l_dbg, l_ie, l_bip, l_um, l_ums, l_vm, l_vms, l_resv;
   logic [AW-1:0] l_raddr, l_rdata;
   logic [4:0]    l_ridx;

   int n_chk = 0;
   int n_err = 0;

   trap_entry_ctrl #(.BASE_VEC(BASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .stall_i(stall), .irq_i(irq), .ext_brk_i(ext_brk),
      .nm_brk_i(nm_brk), .sw_brk_i(sw_brk), .sw_imm_i(sw_imm), .rtbd_i(rtbd),
      .rtid_i(rtid), .eip_i(eip), .dec_pc_i(dec_pc), .ll_vec_i(LLV),
      .st_we_i(st_we), .st_ie_i(st_ie), .st_um_i(st_um), .st_vm_i(st_vm),
      .resv_set_i(resv_set), .redir_o(redir), .redir_addr_o(raddr), .rf_we_o(rf_we),
      .rf_idx_o(ridx), .rf_data_o(rdata), .dbg_req_o(dbg), .msr_ie_o(ie),
      .msr_bip_o(bip), .msr_um_o(um), .msr_ums_o(ums), .msr_vm_o(vm),
      .msr_vms_o(vms), .resv_o(resv)
   );

   trap_entry_ctrl #(.BASE_VEC(BASE), .LOW_LAT_EN(1'b1)) u_dut_ll (
      .clk(clk), .rst_n(rst_n), .stall_i(stall), .irq_i(irq), .ext_brk_i(ext_brk),
      .nm_brk_i(nm_brk), .sw_brk_i(sw_brk), .sw_imm_i(sw_imm), .rtbd_i(rtbd),
      .rtid_i(rtid), .eip_i(eip), .dec_pc_i(dec_pc), .ll_vec_i(LLV),
      .st_we_i(st_we), .st_ie_i(st_ie), .st_um_i(st_um), .st_vm_i(st_vm),
      .resv_set_i(resv_set), .redir_o(l_redir), .redir_addr_o(l_raddr), .rf_we_o(l_rf_we),
      .rf_idx_o(l_ridx), .rf_data_o(l_rdata), .dbg_req_o(l_dbg), .msr_ie_o(l_ie),
      .msr_bip_o(l_bip), .msr_um_o(l_um), .msr_ums_o(l_ums), .msr_vm_o(l_vm),
      .msr_vms_o(l_vms), .resv_o(l_resv)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // advance to the next sampling point: inputs change at negedge, sample 2 ns later
   task automatic step();
      @(negedge clk);
   endtask

   task automatic settle();
      #2;
   endtask

   task automatic idle_inputs();
      stall = 0; irq = 0; ext_brk = 0; nm_brk = 0; sw_brk = 0; sw_imm = '0;
      rtbd = 0; rtid = 0; eip = 0; dec_pc = '0;
      st_we = 0; st_ie = 0; st_um = 0; st_vm = 0; resv_set = 0;
   endtask

   task automatic write_status(input logic i, input logic u, input logic v);
      step(); st_we = 1; st_ie = i; st_um = u; st_vm = v;
      step(); st_we = 0;
   endtask

   task automatic t_reset();
      settle();
      chk("R14 ie", ie, 0);     chk("R14 bip", bip, 0);
      chk("R14 um", um, 0);     chk("R14 vm", vm, 0);
      chk("R14 resv", resv, 0); chk("R14 redir", redir, 0);
      chk("R14 we", rf_we, 0);  chk("R14 dbg", dbg, 0);
   endtask

   task automatic t_status_write();
      step(); st_we = 1; st_ie = 1; st_um = 1; st_vm = 1; resv_set = 1;
      step(); st_we = 0; resv_set = 0; settle();
      chk("R13 ie", ie, 1); chk("R13 um", um, 1);
      chk("R13 vm", vm, 1); chk("R13 resv", resv, 1);
   endtask

   task automatic t_irq();
      step(); irq = 1; dec_pc = 32'h100; settle();
      chk("R2 redir", redir, 1);
      chk("R2 addr", raddr, BASE + 32'h10);
      chk("R2 lowlat addr", l_raddr, LLV);
      chk("R3 we", rf_we, 1); chk("R3 idx", ridx, 14); chk("R3 data", rdata, 32'h100);
      step(); settle();
      chk("R3 ie cleared", ie, 0);
      chk("R1 masked when ie=0", redir, 0);
      step(); rtid = 1; settle();
      chk("R1 still masked in rtid cycle", redir, 0);
      step(); rtid = 0; settle();
      chk("R4 ie set", ie, 1);
      chk("R1 taken again", redir, 1);
      step(); irq = 0;
      write_status(1, 1, 1);
   endtask

   task automatic t_irq_gate();
      step(); irq = 1; eip = 1; settle();
      chk("R1 eip blocks", redir, 0);
      step(); eip = 0; stall = 1; settle();
      chk("R1 stall blocks", redir, 0);
      step(); irq = 0; stall = 0; settle();
      chk("R1 ie kept", ie, 1);
   endtask

   task automatic t_brk_ext();
      step(); resv_set = 1;
      step(); resv_set = 0; ext_brk = 1; irq = 1; dec_pc = 32'h200; settle();
      chk("R12 break wins", ridx, 16);
      chk("R5 addr", raddr, BASE + 32'h18);
      chk("R5 data", rdata, 32'h200);
      step(); settle();
      chk("R5 bip", bip, 1);     chk("R5 resv", resv, 0);
      chk("R6 um", um, 0);       chk("R6 ums", ums, 1);
      chk("R6 vm", vm, 0);       chk("R6 vms", vms, 1);
      chk("R8 ext ignored / R12 irq masked", redir, 0);
      step(); ext_brk = 0; rtbd = 1; settle();
      chk("R12 masked in rtbd cycle", redir, 0);
      step(); rtbd = 0; settle();
      chk("R7 bip", bip, 0); chk("R7 um", um, 1); chk("R7 vm", vm, 1);
      chk("R12 irq after return", raddr, BASE + 32'h10);
      chk("R12 irq idx", ridx, 14);
      step(); irq = 0;
      write_status(1, 1, 1);
   endtask

   task automatic t_nmi_stall();
      step(); ext_brk = 1;
      step(); ext_brk = 0; stall = 1; nm_brk = 1; settle();
      chk("R8 bip set", bip, 1);
      chk("R11 no redirect in stall", redir, 0);
      step(); nm_brk = 0; settle();
      chk("R11 still stalled", redir, 0);
      step(); stall = 0; dec_pc = 32'h300; settle();
      chk("R11 pending taken", redir, 1);
      chk("R8 nm despite bip", raddr, BASE + 32'h18);
      chk("R11 data", rdata, 32'h300);
      step(); settle();
      chk("R11 taken once", redir, 0);
      step(); rtbd = 1;
      step(); rtbd = 0; settle();
      chk("R7 bip cleared", bip, 0);
   endtask

   task automatic t_sw();
      step(); sw_brk = 1; sw_imm = 16'h0040; dec_pc = 32'h500; settle();
      chk("R10 addr", raddr, BASE + 32'h40);
      chk("R10 idx", ridx, 16); chk("R10 data", rdata, 32'h500);
      step(); sw_brk = 0; settle();
      chk("R10 bip", bip, 1);
      step(); rtbd = 1;
      step(); rtbd = 0; sw_brk = 1; sw_imm = 16'h0018; settle();
      chk("R9 dbg", dbg, 1); chk("R9 redir", redir, 0); chk("R9 we", rf_we, 0);
      step(); sw_brk = 0; settle();
      chk("R9 bip unchanged", bip, 0);
      chk("R9 dbg one cycle", dbg, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_status_write();
      t_irq();
      t_irq_gate();
      t_brk_ext();
      t_nmi_stall();
      t_sw();
      step();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule